// File: doc/BRIEF.md
# Micro-op Dispatch Port Router

The router looks at an eight-entry window of ready micro-ops each cycle and decides which of them leave on the four dispatch ports. Port 0 and port 1 each carry a double-rate integer ALU that has two issue slots. Port 0 also carries an FP-move / store-data unit. Port 1 carries a floating-point unit and a complex-integer/shift unit, and both of these can take several cycles per operation. Port 2 takes loads and port 3 takes store addresses. Together they give six issue slots per cycle. A store sits in one window entry and leaves as two micro-ops: the address goes on port 3 and the data goes on port 0.

The window interface follows valid/ready rules. An entry that is presented with `win_valid` and sees its `win_ready` bit high during the cycle has been accepted. An entry that is not accepted must stay presented, unchanged, and it competes again in the next cycle. The grant decision depends only on the current window and on the unit busy counters, so it is made in the same cycle. The FPU and the complex unit each have a busy counter. The counter is loaded from the issuing entry's latency field and counts down to idle. A unit is offered work only when its counter is idle.

Top module: `dpr_router`

## Requirements
- R1: Reset clears both busy counters, so an FP op is granted in the first cycle after reset even when the unit had just been loaded with a long latency. An empty window yields no valid slot, no ready bit and a count of 0.
- R2: Slot map. Slots 0 and 1 are the port-0 ALU, and slot 1 accepts ALU work only. Slots 2 and 3 are port 1, and slot 3 accepts ALU work only. Slot 4 is the port-2 load. Slot 5 is the port-3 store address. Each slot tag is the window entry index.
- R3: Class code 0 (simple integer) takes the first free slot in the order 1, 3, 0, 2. At most four such ops issue per cycle.
- R4: Entries are considered oldest-first, where a lower age value means older. A younger entry takes only the resources that older entries left free.
- R5: Class 1 (complex integer) and class 2 (FP) issue only on slot 2, and only when their unit counter is idle. A grant with latency L (0 is treated as 1) blocks that unit for the next L-1 cycles.
- R6: A busy FPU or complex unit does not stop simple ops from using slots 2 and 3.
- R7: Class 4 (load) issues only on slot 4, at most one per cycle.
- R8: Class 5 (integer store) needs slot 5 plus a port-0 ALU slot, trying slot 1 before slot 0. Class 6 (FP store) needs slot 5 plus slot 0. If either part is unavailable, neither part issues.
- R9: Class 3 (FP move) issues only on slot 0. Class 7 is never granted.
- R10: `issue_count` equals the number of valid slots, with a store counting as two. The count reaches 6.
- R11: `win_ready` is high only for valid entries that were granted. Entries that are invalid or not granted do not appear in any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid | input | 8 | Window entry valid bits |
| win_age | input | 24 | 3-bit age per entry, lower is older |
| win_cls | input | 24 | 3-bit class code per entry |
| win_lat | input | 32 | 4-bit latency per entry |
| win_ready | output | 8 | Entry accepted this cycle |
| slot_valid | output | 6 | Issue slot valid |
| slot_tag | output | 18 | 3-bit entry index per slot |
| issue_count | output | 3 | Micro-ops issued this cycle |

## Verification
The hardest situation to reach is a long FPU operation still counting down while port 1 keeps issuing simple ops into slots 2 and 3, followed by the FPU becoming available again on the exact cycle its latency allows. To reach it, the stimulus grants an FP op with a known latency and then holds the same window presented unchanged. Each following cycle is checked until the FP entry is accepted again. Similar directed windows check the store-pairing failures: an older FP move occupying slot 0, and an older store occupying slot 5 while an ALU slot stays free.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [2:0] {
    CL_SIMPLE = 3'd0,
    CL_CPLX   = 3'd1,
    CL_FP     = 3'd2,
    CL_FMOV   = 3'd3,
    CL_LOAD   = 3'd4,
    CL_ST_INT = 3'd5,
    CL_ST_FP  = 3'd6,
    CL_NONE   = 3'd7
  } cls_e;

  localparam int CLS_W   = 3;
  localparam int N_SLOT  = 6;
  localparam int N_BUSY  = 2;   // 0: FPU, 1: complex integer
  localparam int SL_P3   = 5;   // store address slot
  localparam int SL_P2   = 4;   // load slot
endpackage

// File: rtl/dpr_picker.sv
module dpr_picker
  import dpr_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]        vld,
  input  logic [ENTRIES*IW-1:0]     age,
  input  logic [ENTRIES*CLS_W-1:0]  cls,
  input  logic [N_BUSY-1:0]         unit_free,
  output logic [ENTRIES-1:0]        grant,
  output logic [N_SLOT-1:0]         sv,
  output logic [N_SLOT*IW-1:0]      st,
  output logic [2:0]                cnt,
  output logic [N_BUSY-1:0]         unit_go,
  output logic [N_BUSY*IW-1:0]      unit_idx
);
  int   s0, s1;
  cls_e c;

  always_comb begin
    grant    = '0;
    sv       = '0;
    st       = '0;
    cnt      = '0;
    unit_go  = '0;
    unit_idx = '0;
    s0 = -1;
    s1 = -1;
    c  = CL_NONE;
    for (int a = 0; a < ENTRIES; a++) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (vld[e] && age[e*IW +: IW] == IW'(a)) begin
          c  = cls_e'(cls[e*CLS_W +: CLS_W]);
          s0 = -1;
          s1 = -1;
          case (c)
            CL_SIMPLE: begin
              if (!sv[1])      s0 = 1;
              else if (!sv[3]) s0 = 3;
              else if (!sv[0]) s0 = 0;
              else if (!sv[2]) s0 = 2;
            end
            CL_CPLX:  if (!sv[2] && unit_free[1]) s0 = 2;
            CL_FP:    if (!sv[2] && unit_free[0]) s0 = 2;
            CL_FMOV:  if (!sv[0]) s0 = 0;
            CL_LOAD:  if (!sv[SL_P2]) s0 = SL_P2;
            CL_ST_INT: begin
              if (!sv[SL_P3]) begin
                if (!sv[1])      s0 = 1;
                else if (!sv[0]) s0 = 0;
                if (s0 >= 0)     s1 = SL_P3;
              end
            end
            CL_ST_FP: begin
              if (!sv[SL_P3] && !sv[0]) begin
                s0 = 0;
                s1 = SL_P3;
              end
            end
            default: ;
          endcase
          if (s0 >= 0) begin
            grant[e]           = 1'b1;
            sv[s0]             = 1'b1;
            st[s0*IW +: IW]    = IW'(e);
            cnt                = cnt + 3'd1;
            if (c == CL_FP) begin
              unit_go[0]           = 1'b1;
              unit_idx[0 +: IW]    = IW'(e);
            end
            if (c == CL_CPLX) begin
              unit_go[1]           = 1'b1;
              unit_idx[IW +: IW]   = IW'(e);
            end
          end
          if (s1 >= 0) begin
            sv[s1]          = 1'b1;
            st[s1*IW +: IW] = IW'(e);
            cnt             = cnt + 3'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dpr_busy.sv
module dpr_busy #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LAT_W-1:0] lat,
  output logic             free
);
  logic [LAT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)          left <= '0;
    else if (go)         left <= (lat == '0) ? '0 : lat - LAT_W'(1);
    else if (left != '0) left <= left - LAT_W'(1);
  end

  assign free = (left == '0);
endmodule

// File: rtl/dpr_router.sv
module dpr_router
  import dpr_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int LAT_W   = 4,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ENTRIES-1:0]       win_valid,
  input  logic [ENTRIES*IW-1:0]    win_age,
  input  logic [ENTRIES*CLS_W-1:0] win_cls,
  input  logic [ENTRIES*LAT_W-1:0] win_lat,
  output logic [ENTRIES-1:0]       win_ready,
  output logic [N_SLOT-1:0]        slot_valid,
  output logic [N_SLOT*IW-1:0]     slot_tag,
  output logic [2:0]               issue_count
);
  logic [N_BUSY-1:0]    unit_free;
  logic [N_BUSY-1:0]    unit_go;
  logic [N_BUSY*IW-1:0] unit_idx;

  dpr_picker #(.ENTRIES(ENTRIES)) u_pick (
    .vld      (win_valid),
    .age      (win_age),
    .cls      (win_cls),
    .unit_free(unit_free),
    .grant    (win_ready),
    .sv       (slot_valid),
    .st       (slot_tag),
    .cnt      (issue_count),
    .unit_go  (unit_go),
    .unit_idx (unit_idx)
  );

  for (genvar u = 0; u < N_BUSY; u++) begin : g_unit
    logic [IW-1:0] idx;
    assign idx = unit_idx[u*IW +: IW];
    dpr_busy #(.LAT_W(LAT_W)) u_busy (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (unit_go[u]),
      .lat  (win_lat[idx*LAT_W +: LAT_W]),
      .free (unit_free[u])
    );
  end
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker
  import dpr_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int LAT_W   = 4,
  localparam int IW     = $clog2(ENTRIES)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ENTRIES-1:0]       win_valid,
  input logic [ENTRIES*CLS_W-1:0] win_cls,
  input logic [ENTRIES*LAT_W-1:0] win_lat,
  input logic [ENTRIES-1:0]       win_ready,
  input logic [N_SLOT-1:0]        slot_valid,
  input logic [N_SLOT*IW-1:0]     slot_tag,
  input logic [2:0]               issue_count
);
  logic [IW-1:0] t0, t1, t2, t4, t5;
  cls_e c1, c2, c4;
  logic fp_go;
  logic [LAT_W-1:0] fp_lat, fp_left;

  assign t0 = slot_tag[0*IW +: IW];
  assign t1 = slot_tag[1*IW +: IW];
  assign t2 = slot_tag[2*IW +: IW];
  assign t4 = slot_tag[4*IW +: IW];
  assign t5 = slot_tag[5*IW +: IW];
  assign c1 = cls_e'(win_cls[t1*CLS_W +: CLS_W]);
  assign c2 = cls_e'(win_cls[t2*CLS_W +: CLS_W]);
  assign c4 = cls_e'(win_cls[t4*CLS_W +: CLS_W]);
  assign fp_go  = slot_valid[2] && c2 == CL_FP;
  assign fp_lat = win_lat[t2*LAT_W +: LAT_W];

  always_ff @(posedge clk) begin
    if (!rst_n)             fp_left <= '0;
    else if (fp_go)         fp_left <= (fp_lat == '0) ? '0 : fp_lat - LAT_W'(1);
    else if (fp_left != '0) fp_left <= fp_left - LAT_W'(1);
  end

  assert_ready_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (win_ready & ~win_valid) == '0);
  assert_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    issue_count == 3'($countones(slot_valid)));
  assert_store_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid[5] |-> ((slot_valid[0] && t0 == t5) || (slot_valid[1] && t1 == t5)));
  assert_load_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid[4] |-> c4 == CL_LOAD);
  assert_alu_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid[1] |-> (c1 == CL_SIMPLE || c1 == CL_ST_INT));
  assert_fpu_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fp_go |-> fp_left == '0);
endmodule

bind dpr_router dpr_checker #(.ENTRIES(ENTRIES), .LAT_W(LAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .win_valid  (win_valid),
  .win_cls    (win_cls),
  .win_lat    (win_lat),
  .win_ready  (win_ready),
  .slot_valid (slot_valid),
  .slot_tag   (slot_tag),
  .issue_count(issue_count)
);

// File: tb/sim_dpr_router.sv
module sim_dpr_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  win_valid;
  logic [23:0] win_age;
  logic [23:0] win_cls;
  logic [31:0] win_lat;
  logic [7:0]  win_ready;
  logic [5:0]  slot_valid;
  logic [17:0] slot_tag;
  logic [2:0]  issue_count;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dpr_router u0 (.*);

  task automatic clr();
    win_valid = '0; win_age = '0; win_cls = {8{3'd7}}; win_lat = '0;
  endtask

  task automatic ent(input int e, input int age, input int cls, input int lat);
    win_valid[e] = 1'b1;
    win_age[e*3 +: 3] = 3'(age);
    win_cls[e*3 +: 3] = 3'(cls);
    win_lat[e*4 +: 4] = 4'(lat);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; clr();
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic chk(input string req, input [5:0] esv, input [17:0] etag,
                     input [7:0] erdy, input int ecnt);
    logic [17:0] mask;
    for (int s = 0; s < 6; s++) mask[s*3 +: 3] = {3{esv[s]}};
    n_chk++;
    if (slot_valid !== esv || (slot_tag & mask) !== (etag & mask) ||
        win_ready !== erdy || issue_count !== 3'(ecnt)) begin
      n_fail++;
      $display("FAIL %s: sv=%b tag=%h rdy=%h cnt=%0d exp sv=%b tag=%h rdy=%h cnt=%0d",
               req, slot_valid, slot_tag & mask, win_ready, issue_count,
               esv, etag & mask, erdy, ecnt);
    end
  endtask

  // tags packed as {t5,t4,t3,t2,t1,t0}
  function automatic [17:0] tg(int a5, int a4, int a3, int a2, int a1, int a0);
    return {3'(a5), 3'(a4), 3'(a3), 3'(a2), 3'(a1), 3'(a0)};
  endfunction

  task automatic t_reset();
    do_reset();
    #1 chk("R1 empty", 6'b0, '0, 8'h00, 0);
    @(negedge clk); ent(0, 0, 2, 9);
    #1 chk("R1 fp first", 6'b000100, tg(0,0,0,0,0,0), 8'h01, 1);
    @(posedge clk);
    do_reset();
    ent(0, 0, 2, 9);
    #1 chk("R1 counter cleared", 6'b000100, tg(0,0,0,0,0,0), 8'h01, 1);
  endtask

  task automatic t_simple_order();
    do_reset();
    for (int e = 0; e < 6; e++) ent(e, 5 - e, 0, 1);
    #1 chk("R3 R4 simple fill", 6'b001111, tg(0,0,4,2,5,3), 8'h3C, 4);
  endtask

  task automatic t_full();
    do_reset();
    ent(0, 0, 5, 1); ent(1, 1, 4, 1);
    ent(2, 2, 0, 1); ent(3, 3, 0, 1); ent(4, 4, 0, 1);
    #1 chk("R10 R2 six issues", 6'b111111, tg(0,1,2,4,0,3), 8'h1F, 6);
  endtask

  task automatic t_store();
    do_reset();
    ent(0, 0, 3, 1); ent(1, 1, 6, 1); ent(2, 2, 5, 1);
    ent(3, 3, 4, 1); ent(4, 4, 4, 1);
    #1 chk("R8 R9 R7 fmov blocks fp store", 6'b110011, tg(2,3,0,0,2,0), 8'h0D, 4);
    @(negedge clk); clr();
    ent(0, 0, 6, 1); ent(1, 1, 3, 1); ent(2, 2, 5, 1);
    #1 chk("R8 both or none", 6'b100001, tg(0,0,0,0,0,0), 8'h01, 2);
  endtask

  task automatic t_fpu_busy();
    do_reset();
    ent(0, 0, 2, 4);
    for (int e = 1; e < 5; e++) ent(e, e, 0, 1);
    #1 chk("R5 fp issue", 6'b001111, tg(0,0,2,0,1,3), 8'h0F, 4);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      #1 chk("R6 R5 fp busy alu runs", 6'b001111, tg(0,0,2,4,1,3), 8'h1E, 4);
    end
    @(negedge clk);
    #1 chk("R5 fp free after latency", 6'b001111, tg(0,0,2,0,1,3), 8'h0F, 4);
  endtask

  task automatic t_cplx();
    do_reset();
    ent(0, 1, 1, 1); ent(1, 0, 2, 2);
    #1 chk("R4 R5 older fp wins slot2", 6'b000100, tg(0,0,0,1,0,0), 8'h02, 1);
    @(negedge clk);
    #1 chk("R5 cplx while fp busy", 6'b000100, tg(0,0,0,0,0,0), 8'h01, 1);
    @(negedge clk); clr(); ent(0, 0, 1, 0);
    #1 chk("R5 cplx lat0", 6'b000100, tg(0,0,0,0,0,0), 8'h01, 1);
    @(negedge clk);
    #1 chk("R5 cplx back to back", 6'b000100, tg(0,0,0,0,0,0), 8'h01, 1);
  endtask

  task automatic t_ignore();
    do_reset();
    ent(0, 0, 7, 1); ent(1, 1, 0, 1); win_valid[1] = 1'b0; ent(2, 2, 0, 1);
    #1 chk("R11 R9 invalid and class7 ignored", 6'b000010, tg(0,0,0,0,2,0), 8'h04, 1);
  endtask

  initial begin
    clr();
    t_reset();
    t_simple_order();
    t_full();
    t_store();
    t_fpu_busy();
    t_cplx();
    t_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule